// File: doc/BRIEF.md
# Doubleword Multiply-Accumulate Execute Unit

This unit executes one narrow family of 32-bit instruction words. Each word multiplies two 32-bit general registers into a full 64-bit product. The product then either replaces an even/odd register pair or is added to or subtracted from that pair. The unit holds a 32 x 32-bit register file, decodes the instruction fields, chooses signed or unsigned operand extension and performs the accumulate. A debug port lets the surrounding logic, or a testbench, load registers directly.

One instruction word may be presented per clock, qualified by `insn_valid`. On the next clock the unit either commits the 64-bit result and pulses `done`, or rejects the word and pulses `illegal`. The committed 64-bit value is also shown on `result`, so that each operation can be observed at the ports. A word issued right after another one sees the pair that the earlier word just wrote.

Top module: `dmac_unit`

## Requirements
- R1: During and straight after a synchronous active-high reset, `done`, `illegal` and `result` are all zero.
- R2: A word with bits 31:28 = 1110, bits 27:24 = 0101, major field (bits 23:21) = 000 and minor field (bits 7:5) = 000 writes the two's-complement product of registers rs (bits 20:16) and rt (bits 12:8) to the pair named by bits 4:0. On the next clock `done` is 1 and `result` equals that product.
- R3: The same word with major field 010 multiplies the two registers as unsigned numbers.
- R4: With bits 27:24 = 0111 and minor 000, the major field selects the accumulating forms: 000 pair += signed product, 001 pair -= signed product, 010 pair += unsigned product, 011 pair -= unsigned product. The arithmetic wraps modulo 2^64, with no shift and no saturation.
- R5: For an even destination d, register d receives bits 31:0 of the result and register d+1 receives bits 63:32.
- R6: The unit rejects a valid word when any of these holds: bits 31:28 are not 1110; the destination is odd; the minor field is not 000; or the form/major combination is not listed in R2–R4. A rejected word pulses `illegal` on the next clock, leaves `done` low and `result` unchanged, and writes no register.
- R7: Bits 15:13 of the word have no effect on the operation.
- R8: A new word is accepted every clock. A word that reads a register written by the word in the previous cycle uses the new value.
- R9: A debug write stores `dbg_wdata` into register `dbg_addr`. It is dropped in any cycle in which an accepted word writes a pair in the same parity bank.
- R10: `done` and `illegal` are one-cycle pulses. They are never both high, and they appear only on the clock after `insn_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn_word | input | 32 | Instruction word |
| dbg_we | input | 1 | Debug register write enable |
| dbg_addr | input | 5 | Debug write register index |
| dbg_wdata | input | 32 | Debug write data |
| done | output | 1 | Result committed (registered pulse) |
| illegal | output | 1 | Word rejected (registered pulse) |
| result | output | 64 | Last committed 64-bit pair value |

## Verification
Every result is due exactly one clock after the word is sampled. The register pair is updated on that same edge, so `done`, `illegal` and `result` are all read at the falling edge that follows the sampling edge. Back-to-back words are driven on consecutive falling edges, and each result is read one half-cycle before the next word is applied. Pair contents that are not shown directly are read out by a later accumulate with a zero product, or by an unsigned multiply by one, each checked at its own one-cycle point.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int XLEN    = 32;
  localparam int DLEN    = 2 * XLEN;
  localparam int RIDX_W  = 5;
  localparam int BIDX_W  = RIDX_W - 1;

  localparam logic [3:0] CLASS_MUL   = 4'b1110;
  localparam logic [3:0] FORM_PLAIN  = 4'b0101;
  localparam logic [3:0] FORM_ACCUM  = 4'b0111;

  typedef struct packed {
    logic              legal;
    logic              accum;
    logic              is_unsigned;
    logic              subtract;
    logic [RIDX_W-1:0] src_a;
    logic [RIDX_W-1:0] src_b;
    logic [RIDX_W-1:0] dst;
  } dec_t;
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
  import dmac_pkg::*;
(
  input  logic [3:0]        f_class,
  input  logic [3:0]        f_form,
  input  logic [2:0]        f_major,
  input  logic [RIDX_W-1:0] f_src_a,
  input  logic [RIDX_W-1:0] f_src_b,
  input  logic [2:0]        f_minor,
  input  logic [RIDX_W-1:0] f_dst,
  output dec_t              dec
);
  logic op_ok;

  always_comb begin
    op_ok = 1'b0;
    if (f_form == FORM_PLAIN)
      op_ok = (f_major == 3'b000) || (f_major == 3'b010);
    else if (f_form == FORM_ACCUM)
      op_ok = (f_major[2] == 1'b0);
  end

  always_comb begin
    dec.legal       = (f_class == CLASS_MUL) && op_ok &&
                      (f_minor == 3'b000) && !f_dst[0];
    dec.accum       = (f_form == FORM_ACCUM);
    dec.is_unsigned = f_major[1];
    dec.subtract    = f_major[0] && (f_form == FORM_ACCUM);
    dec.src_a       = f_src_a;
    dec.src_b       = f_src_b;
    dec.dst         = f_dst;
  end
endmodule

// File: rtl/dmac_bank.sv
module dmac_bank #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    ra_a,
  input  logic [AW-1:0]    ra_b,
  input  logic [AW-1:0]    ra_c,
  output logic [WIDTH-1:0] rd_a,
  output logic [WIDTH-1:0] rd_b,
  output logic [WIDTH-1:0] rd_c
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
  assign rd_c = mem[ra_c];
endmodule

// File: rtl/dmac_mulacc.sv
module dmac_mulacc
  import dmac_pkg::*;
(
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [DLEN-1:0] pair,
  input  logic            is_unsigned,
  input  logic            accum,
  input  logic            subtract,
  output logic [DLEN-1:0] res
);
  logic [DLEN-1:0] ext_a, ext_b, prod;

  always_comb begin
    ext_a = {{XLEN{opa[XLEN-1] & ~is_unsigned}}, opa};
    ext_b = {{XLEN{opb[XLEN-1] & ~is_unsigned}}, opb};
    prod  = ext_a * ext_b;
    if (!accum)        res = prod;
    else if (subtract) res = pair - prod;
    else               res = pair + prod;
  end
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
  import dmac_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int BANK_DEPTH = NREGS / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [31:0]       insn_word,
  input  logic              dbg_we,
  input  logic [RIDX_W-1:0] dbg_addr,
  input  logic [XLEN-1:0]   dbg_wdata,
  output logic              done,
  output logic              illegal,
  output logic [DLEN-1:0]   result
);
  dec_t            dec;
  logic            exec_wr;
  logic [XLEN-1:0] rd_a [2];
  logic [XLEN-1:0] rd_b [2];
  logic [XLEN-1:0] rd_p [2];
  logic [XLEN-1:0] opa, opb;
  logic [DLEN-1:0] new_pair;

  dmac_decode u_dec (
    .f_class (insn_word[31:28]),
    .f_form  (insn_word[27:24]),
    .f_major (insn_word[23:21]),
    .f_src_a (insn_word[20:16]),
    .f_src_b (insn_word[12:8]),
    .f_minor (insn_word[7:5]),
    .f_dst   (insn_word[4:0]),
    .dec     (dec)
  );

  assign exec_wr = insn_valid && dec.legal;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic              b_we;
    logic [BIDX_W-1:0] b_waddr;
    logic [XLEN-1:0]   b_wdata;

    always_comb begin
      if (exec_wr) begin
        b_we    = 1'b1;
        b_waddr = dec.dst[RIDX_W-1:1];
        b_wdata = new_pair[g*XLEN +: XLEN];
      end else begin
        b_we    = dbg_we && (dbg_addr[0] == g[0]);
        b_waddr = dbg_addr[RIDX_W-1:1];
        b_wdata = dbg_wdata;
      end
    end

    dmac_bank #(.WIDTH(XLEN), .DEPTH(BANK_DEPTH)) u_bank (
      .clk   (clk),
      .we    (b_we),
      .waddr (b_waddr),
      .wdata (b_wdata),
      .ra_a  (dec.src_a[RIDX_W-1:1]),
      .ra_b  (dec.src_b[RIDX_W-1:1]),
      .ra_c  (dec.dst[RIDX_W-1:1]),
      .rd_a  (rd_a[g]),
      .rd_b  (rd_b[g]),
      .rd_c  (rd_p[g])
    );
  end

  assign opa = rd_a[dec.src_a[0]];
  assign opb = rd_b[dec.src_b[0]];

  dmac_mulacc u_mac (
    .opa         (opa),
    .opb         (opb),
    .pair        ({rd_p[1], rd_p[0]}),
    .is_unsigned (dec.is_unsigned),
    .accum       (dec.accum),
    .subtract    (dec.subtract),
    .res         (new_pair)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      illegal <= 1'b0;
      result  <= '0;
    end else begin
      done    <= exec_wr;
      illegal <= insn_valid && !dec.legal;
      if (exec_wr) result <= new_pair;
    end
  end
endmodule

// File: rtl/dmac_unit_chk.sv
module dmac_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        insn_valid,
  input logic        done,
  input logic        illegal,
  input logic [63:0] result
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!done && !illegal && result == 64'd0));

  assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, illegal}));

  assert_no_output_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=> (!done && !illegal));

  assert_reject_holds_result_R6: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(result));

  assert_issue_answers_R8: assert property (@(posedge clk) disable iff (rst)
    insn_valid |=> (done || illegal));
endmodule

bind dmac_unit dmac_unit_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .insn_valid (insn_valid),
  .done       (done),
  .illegal    (illegal),
  .result     (result)
);

// File: tb/test_dmac_unit.sv
module test_dmac_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        insn_valid;
  logic [31:0] insn_word;
  logic        dbg_we;
  logic [4:0]  dbg_addr;
  logic [31:0] dbg_wdata;
  logic        done, illegal;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dmac_unit i_dmac_unit (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .done(done), .illegal(illegal), .result(result)
  );

  // {accum, major[2:0], a[31:0], b[31:0], initial pair[63:0]}
  localparam int NV = 10;
  localparam logic [131:0] VEC [NV] = '{
    {1'b0, 3'b000, 32'h8000_0000, 32'h8000_0000, 64'h0},
    {1'b0, 3'b010, 32'h8000_0000, 32'h8000_0000, 64'h0},
    {1'b0, 3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0},
    {1'b0, 3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0},
    {1'b0, 3'b000, 32'h0001_2345, 32'hFFFF_FF00, 64'h1234},
    {1'b1, 3'b000, 32'hFFFF_FFFE, 32'h0000_0003, 64'h0000_0001_0000_0000},
    {1'b1, 3'b001, 32'h8000_0000, 32'h8000_0000, 64'h0},
    {1'b1, 3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0},
    {1'b1, 3'b011, 32'h0000_0007, 32'h0000_0009, 64'hDEAD_BEEF_0000_0100}
  };

  function automatic logic [31:0] enc(logic [3:0] form, logic [2:0] maj,
                                      logic [4:0] rs, logic [4:0] rt,
                                      logic [2:0] minor, logic [4:0] rd);
    return {4'hE, form, maj, rs, 3'b000, rt, minor, rd};
  endfunction

  function automatic logic [63:0] model(logic acc, logic [2:0] maj,
                                        logic [31:0] a, logic [31:0] b,
                                        logic [63:0] init);
    logic [63:0] ea, eb, p;
    ea = maj[1] ? {32'h0, a} : {{32{a[31]}}, a};
    eb = maj[1] ? {32'h0, b} : {{32{b[31]}}, b};
    p  = ea * eb;
    if (!acc) return p;
    return maj[0] ? init - p : init + p;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  // drives one word; outputs are read at the following falling edge
  task automatic issue(logic [31:0] w);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = w;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  // reads the pair at d via pair += 0 * 0 (r0 holds zero)
  task automatic read_pair(logic [4:0] d, output logic [63:0] v);
    issue(enc(4'b0111, 3'b000, 5'd0, 5'd0, 3'b000, d));
    v = result;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    rst = 1'b1; insn_valid = 1'b0; insn_word = '0;
    dbg_we = 1'b0; dbg_addr = '0; dbg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1
    check("R1", {62'h0, done, illegal}, 64'h0);
    check("R1", result, 64'h0);
    rst = 1'b0;
    wr(5'd0, 32'h0);
    wr(5'd1, 32'h1);

    // table walk: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      logic        acc;
      logic [2:0]  maj;
      logic [31:0] a, b;
      logic [63:0] init;
      {acc, maj, a, b, init} = VEC[i];
      wr(5'd21, a); wr(5'd31, b);
      wr(5'd16, init[31:0]); wr(5'd17, init[63:32]);
      issue(enc(acc ? 4'b0111 : 4'b0101, maj, 5'd21, 5'd31, 3'b000, 5'd16));
      check(acc ? "R4" : (maj[1] ? "R3" : "R2"), {63'h0, done}, 64'h1);
      check(acc ? "R4" : (maj[1] ? "R3" : "R2"), result, model(acc, maj, a, b, init));
    end

    // R5: low word at r16, high at r17 (read back as unsigned x 1)
    wr(5'd21, 32'h8765_4321); wr(5'd31, 32'h1234_5678);
    issue(32'hE555DF10);
    v = model(1'b0, 3'b010, 32'h8765_4321, 32'h1234_5678, 64'h0);
    issue(enc(4'b0101, 3'b010, 5'd16, 5'd1, 3'b000, 5'd4));
    check("R5", result, {32'h0, v[31:0]});
    issue(enc(4'b0101, 3'b010, 5'd17, 5'd1, 3'b000, 5'd4));
    check("R5", result, {32'h0, v[63:32]});

    // R7: same word with bits 15:13 cleared and set gives the same result
    issue(32'hE5151F10);
    v = result;
    issue(32'hE515FF10);
    check("R7", result, v);
    check("R7", v, model(1'b0, 3'b000, 32'h8765_4321, 32'h1234_5678, 64'h0));
    issue(32'hE735DF10);
    check("R4", result, 64'h0);
    issue(32'hE775DF10);
    check("R4", result, 64'h0 - model(1'b0, 3'b010, 32'h8765_4321, 32'h1234_5678, 64'h0));

    // R6: rejected words leave the pair untouched
    wr(5'd16, 32'hAAAA_5555); wr(5'd17, 32'h0F0F_F0F0);
    issue(enc(4'b0101, 3'b000, 5'd21, 5'd31, 3'b000, 5'd17));
    check("R6 odd dst", {62'h0, done, illegal}, 64'h1);
    issue(enc(4'b0101, 3'b001, 5'd21, 5'd31, 3'b000, 5'd16));
    check("R6 bad major", {62'h0, done, illegal}, 64'h1);
    issue(enc(4'b0111, 3'b100, 5'd21, 5'd31, 3'b000, 5'd16));
    check("R6 bad major acc", {62'h0, done, illegal}, 64'h1);
    issue(enc(4'b0101, 3'b000, 5'd21, 5'd31, 3'b001, 5'd16));
    check("R6 bad minor", {62'h0, done, illegal}, 64'h1);
    issue({4'hD, 28'h515DF10});
    check("R6 bad class", {62'h0, done, illegal}, 64'h1);
    issue({4'hE, 4'h6, 24'h15DF10});
    check("R6 bad form", {62'h0, done, illegal}, 64'h1);
    read_pair(5'd16, v);
    check("R6 no write", v, 64'h0F0F_F0F0_AAAA_5555);

    // R8: back-to-back with dependency on the just-written pair
    wr(5'd2, 32'd3); wr(5'd3, 32'd5);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = enc(4'b0101, 3'b000, 5'd2, 5'd3, 3'b000, 5'd8);
    @(negedge clk);
    check("R8 first", result, 64'd15);
    insn_word = enc(4'b0101, 3'b010, 5'd8, 5'd3, 3'b000, 5'd10);
    @(negedge clk);
    check("R8 second", result, 64'd75);
    check("R8 done", {63'h0, done}, 64'h1);
    insn_word = enc(4'b0111, 3'b001, 5'd9, 5'd9, 3'b000, 5'd10);
    @(negedge clk);
    insn_valid = 1'b0;
    check("R8 third", result, 64'd75);
    @(negedge clk);
    check("R10 pulse", {62'h0, done, illegal}, 64'h0);

    // R9: debug write into the bank of an executing pair is dropped
    wr(5'd6, 32'h0000_0042);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = enc(4'b0101, 3'b000, 5'd2, 5'd3, 3'b000, 5'd8);
    dbg_we = 1'b1; dbg_addr = 5'd6; dbg_wdata = 32'h0000_0099;
    @(negedge clk);
    insn_valid = 1'b0; dbg_we = 1'b0;
    issue(enc(4'b0101, 3'b010, 5'd6, 5'd1, 3'b000, 5'd4));
    check("R9 dropped", result, 64'h42);
    wr(5'd6, 32'h0000_0077);
    issue(enc(4'b0101, 3'b010, 5'd6, 5'd1, 3'b000, 5'd4));
    check("R9 write", result, 64'h77);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule